// File: doc/BRIEF.md
# Modem Handshake Status and Control Unit

This unit serves the handshake lines of a single serial channel. It takes four active-low handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) and passes them through a synchroniser. It shows their asserted state in true form in an 8-bit status byte. Next to each level it keeps a sticky change flag that records a transition. Reading the status byte clears the flags.

A small control register drives the active-low request-to-send and data-terminal-ready outputs. One bit of that register selects a diagnostic loopback. In loopback the four status levels come from control bits instead of from the pins, and both outputs are held inactive. An interrupt request is raised while any change flag is set and the modem-status interrupt enable input is high.

Top module: `modem_ctl`

## Requirements
- R1: After reset, with all four inputs held high, `stat_rdata` is 0x00, `ctrl_rdata` is 0x00, `rts_n` and `dtr_n` are 1 and `irq` is 0.
- R2: `stat_rdata` bits 4, 5, 6 and 7 report the asserted (inverted) level of `cts_n`, `dsr_n`, `ri_n` and `dcd_n` respectively. A change that `cts_n` presents before clock edge 1 shows at the output after edge 3 and not after edge 2.
- R3: `stat_rdata` bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) set on every transition of their line, in either direction.
- R4: `stat_rdata` bit 2 sets only when the ring indicator goes from asserted to deasserted, which is `ri_n` going 0 to 1. A newly asserted ring leaves the bit unchanged.
- R5: A change flag that is set stays set while no read occurs, however many cycles pass.
- R6: A cycle with `stat_rd` high returns the status with its flags still set. At the clock edge that ends that cycle, bits 3:0 clear.
- R7: A transition that is detected at the same edge that ends a read leaves its flag set after the read.
- R8: A write with `ctrl_wr` stores `ctrl_wdata[4:0]`, and `ctrl_rdata` returns them with bits 7:5 as zero. Outside loopback, `dtr_n` is the inverse of control bit 0 and `rts_n` is the inverse of control bit 1 from the cycle after the write.
- R9: While control bit 4 is 1, the status levels follow control bits 1, 0, 2 and 3 for clear-to-send, data-set-ready, ring and carrier detect, and the external inputs have no effect. `rts_n` and `dtr_n` stay 1.
- R10: `irq` is 1 exactly when `msi_en` is 1 and at least one of `stat_rdata[3:0]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Control register contents |
| stat_rd | input | 1 | Status read strobe; clears change flags at the end of the cycle |
| stat_rdata | output | 8 | Levels in bits 7:4, change flags in bits 3:0 |
| msi_en | input | 1 | Modem-status interrupt enable |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The two functions that can meet in one cycle are the read-clear of the change flags and the setting of a flag by a newly detected transition. The bench counts the synchroniser delay so that a clear-to-send edge reaches the detector at the exact edge that ends a status read. In the same test a different flag is already set. The check requires that the read returns the old flags, that the already-set flag is cleared and that the new flag survives.

// File: rtl/msc_pkg.sv
package msc_pkg;
   localparam int NUM_LINES = 4;

   // line index inside the level / change vectors (status bit = index, level = index + 4)
   localparam int LN_CTS = 0;
   localparam int LN_DSR = 1;
   localparam int LN_RI  = 2;
   localparam int LN_DCD = 3;

   // control register bit positions
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_AUX1 = 2;
   localparam int CB_AUX2 = 3;
   localparam int CB_LOOP = 4;

   typedef logic [NUM_LINES-1:0] line_vec_t;
endpackage

// File: rtl/msc_sync.sv
module msc_sync #(
   parameter int              WIDTH   = 4,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("msc_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("msc_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/msc_delta.sv
module msc_delta #(
   parameter int                   LINES      = 4,
   parameter logic [LINES-1:0]     TRAIL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] act,
   input  logic             rd,
   output logic [LINES-1:0] lvl_q,
   output logic [LINES-1:0] dlt_q
);
   generate
      if (LINES < 1) begin : g_bad_lines
         $error("msc_delta: LINES must be positive");
      end
   endgenerate

   logic [LINES-1:0] hit;

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         if (TRAIL_MASK[g]) begin : g_trail
            // only asserted -> deasserted counts
            assign hit[g] = lvl_q[g] & ~act[g];

            AST_TRAIL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
               !lvl_q[g] && !dlt_q[g] |=> !dlt_q[g]); // R4
         end else begin : g_any
            assign hit[g] = lvl_q[g] ^ act[g];
         end

         AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            dlt_q[g] && !rd |=> dlt_q[g]); // R5
         AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            rd && !hit[g] |=> !dlt_q[g]); // R6
         AST_HIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> dlt_q[g]); // R7
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         dlt_q <= '0;
      end else begin
         lvl_q <= act;
         // a fresh hit outranks the read clear
         dlt_q <= (dlt_q & ~{LINES{rd}}) | hit;
      end
   end
endmodule

// File: rtl/msc_ctrl.sv
module msc_ctrl
   import msc_pkg::*;
#(
   parameter int CTRL_W = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              loop_en,
   output line_vec_t         loop_src,
   output logic              rts_n,
   output logic              dtr_n
);
   generate
      if (CTRL_W < CB_LOOP + 1 || CTRL_W > DATA_W) begin : g_bad_w
         $error("msc_ctrl: CTRL_W must hold the loop bit and fit the data bus");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (wr) ctrl_q <= wdata[CTRL_W-1:0];
   end

   assign loop_en = ctrl_q[CB_LOOP];

   always_comb begin
      loop_src         = '0;
      loop_src[LN_CTS] = ctrl_q[CB_RTS];
      loop_src[LN_DSR] = ctrl_q[CB_DTR];
      loop_src[LN_RI]  = ctrl_q[CB_AUX1];
      loop_src[LN_DCD] = ctrl_q[CB_AUX2];
   end

   assign rts_n = loop_en | ~ctrl_q[CB_RTS];
   assign dtr_n = loop_en | ~ctrl_q[CB_DTR];

   AST_LOOP_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr && wdata[CB_LOOP] |=> rts_n && dtr_n); // R9
   AST_DTR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      wr && !wdata[CB_LOOP] |=> dtr_n == !$past(wdata[CB_DTR])); // R8
   AST_RTS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      wr && !wdata[CB_LOOP] |=> rts_n == !$past(wdata[CB_RTS])); // R8
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
   import msc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CTRL_W      = 5,
   parameter int DATA_W      = 8,
   parameter bit RI_TRAILING = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cts_n,
   input  logic              dsr_n,
   input  logic              ri_n,
   input  logic              dcd_n,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] ctrl_wdata,
   output logic [DATA_W-1:0] ctrl_rdata,
   input  logic              stat_rd,
   output logic [DATA_W-1:0] stat_rdata,
   input  logic              msi_en,
   output logic              rts_n,
   output logic              dtr_n,
   output logic              irq
);
   localparam int STAT_W = 2 * NUM_LINES;
   localparam line_vec_t TRAIL_MASK = RI_TRAILING ? line_vec_t'(1 << LN_RI) : '0;

   generate
      if (DATA_W < STAT_W) begin : g_bad_data_w
         $error("modem_ctl: DATA_W must hold levels and flags");
      end
   endgenerate

   line_vec_t         pin_n;
   line_vec_t         sync_n;
   line_vec_t         loop_src;
   line_vec_t         act;
   line_vec_t         lvl_q;
   line_vec_t         dlt_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              loop_en;

   always_comb begin
      pin_n         = '1;
      pin_n[LN_CTS] = cts_n;
      pin_n[LN_DSR] = dsr_n;
      pin_n[LN_RI]  = ri_n;
      pin_n[LN_DCD] = dcd_n;
   end

   msc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d (pin_n),
      .q (sync_n)
   );

   msc_ctrl #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_ctrl (
      .clk (clk),
      .rst_n (rst_n),
      .wr (ctrl_wr),
      .wdata (ctrl_wdata),
      .ctrl_q (ctrl_q),
      .loop_en (loop_en),
      .loop_src (loop_src),
      .rts_n (rts_n),
      .dtr_n (dtr_n)
   );

   assign act = loop_en ? loop_src : ~sync_n;

   msc_delta #(.LINES(NUM_LINES), .TRAIL_MASK(TRAIL_MASK)) u_delta (
      .clk (clk),
      .rst_n (rst_n),
      .act (act),
      .rd (stat_rd),
      .lvl_q (lvl_q),
      .dlt_q (dlt_q)
   );

   always_comb begin
      stat_rdata                     = '0;
      stat_rdata[NUM_LINES-1:0]      = dlt_q;
      stat_rdata[STAT_W-1:NUM_LINES] = lvl_q;
      ctrl_rdata                     = '0;
      ctrl_rdata[CTRL_W-1:0]         = ctrl_q;
   end

   assign irq = msi_en & (|dlt_q);

   AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> msi_en && (|stat_rdata[NUM_LINES-1:0])); // R10
   AST_LOOP_CTS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en && $stable(ctrl_q) |=> stat_rdata[NUM_LINES+LN_CTS] == $past(ctrl_q[CB_RTS])); // R9
   AST_LOOP_DSR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en && $stable(ctrl_q) |=> stat_rdata[NUM_LINES+LN_DSR] == $past(ctrl_q[CB_DTR])); // R9
endmodule

// File: tb/modem_ctl_tb.sv
module modem_ctl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
   logic       ctrl_wr = 1'b0;
   logic [7:0] ctrl_wdata = 8'h00;
   logic [7:0] ctrl_rdata;
   logic       stat_rd = 1'b0;
   logic [7:0] stat_rdata;
   logic       msi_en = 1'b0;
   logic       rts_n, dtr_n, irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   modem_ctl u_dut (
      .clk (clk), .rst_n (rst_n),
      .cts_n (cts_n), .dsr_n (dsr_n), .ri_n (ri_n), .dcd_n (dcd_n),
      .ctrl_wr (ctrl_wr), .ctrl_wdata (ctrl_wdata), .ctrl_rdata (ctrl_rdata),
      .stat_rd (stat_rd), .stat_rdata (stat_rdata), .msi_en (msi_en),
      .rts_n (rts_n), .dtr_n (dtr_n), .irq (irq)
   );

   task automatic chk(input string tag, input logic [7:0] actual, input logic [7:0] expected);
      checks++;
      if (actual !== expected) begin
         errors++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, actual, expected);
      end
   endtask

   task automatic write_ctrl(input logic [7:0] v);
      @(negedge clk);
      ctrl_wr = 1'b1;
      ctrl_wdata = v;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   // returns the value shown during the read cycle; flags clear at its closing edge
   task automatic read_stat(output logic [7:0] v);
      @(negedge clk);
      stat_rd = 1'b1;
      #1 v = stat_rdata;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 status", stat_rdata, 8'h00);
      chk("R1 ctrl", ctrl_rdata, 8'h00);
      chk("R1 pins rts/dtr/irq", {5'd0, rts_n, dtr_n, irq}, 8'h06);
   endtask

   task automatic t_ctrl();
      write_ctrl(8'h01);
      chk("R8 dtr set", {6'd0, rts_n, dtr_n}, 8'h02);
      write_ctrl(8'h02);
      chk("R8 rts set", {6'd0, rts_n, dtr_n}, 8'h01);
      write_ctrl(8'hEF);
      chk("R8 readback masks 7:5", ctrl_rdata, 8'h0F);
      chk("R8 both asserted", {6'd0, rts_n, dtr_n}, 8'h00);
      write_ctrl(8'h00);
      chk("R8 both released", {6'd0, rts_n, dtr_n}, 8'h03);
   endtask

   task automatic t_levels();
      logic [7:0] v;
      @(negedge clk);
      cts_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 not yet after two edges", stat_rdata, 8'h00);
      @(negedge clk);
      chk("R2 R3 cts level and flag", stat_rdata, 8'h11);
      read_stat(v);
      chk("R6 read shows flag", v, 8'h11);
      chk("R6 flag cleared", stat_rdata, 8'h10);
      dsr_n = 1'b0;
      dcd_n = 1'b0;
      settle();
      chk("R2 R3 dsr dcd", stat_rdata, 8'hBA);
      read_stat(v);
      chk("R6 cleared again", stat_rdata, 8'hB0);
   endtask

   task automatic t_ri();
      logic [7:0] v;
      ri_n = 1'b0;
      settle();
      chk("R4 ring asserted no flag", stat_rdata, 8'hF0);
      ri_n = 1'b1;
      settle();
      chk("R4 ring trailing edge flag", stat_rdata, 8'hB4);
      read_stat(v);
      chk("R4 cleared", stat_rdata, 8'hB0);
   endtask

   task automatic t_sticky_irq();
      logic [7:0] v;
      cts_n = 1'b1;
      settle();
      chk("R10 disabled no irq", {7'd0, irq}, 8'h00);
      repeat (20) @(negedge clk);
      chk("R5 flag held", stat_rdata, 8'hA1);
      msi_en = 1'b1;
      #1 chk("R10 enabled irq", {7'd0, irq}, 8'h01);
      read_stat(v);
      chk("R10 irq drops after read", {7'd0, irq}, 8'h00);
      msi_en = 1'b0;
   endtask

   task automatic t_coincide();
      logic [7:0] v;
      dsr_n = 1'b1;
      dcd_n = 1'b1;
      settle();
      chk("R3 release flags", stat_rdata, 8'h0A);
      @(negedge clk);
      cts_n = 1'b0;          // reaches the detector at the third edge from here
      @(negedge clk);
      @(negedge clk);
      stat_rd = 1'b1;        // read cycle ends at that same third edge
      #1 v = stat_rdata;
      @(negedge clk);
      stat_rd = 1'b0;
      chk("R6 read shows old flags", v, 8'h0A);
      chk("R7 new flag kept, old cleared", stat_rdata, 8'h11);
      read_stat(v);
   endtask

   task automatic t_loop();
      logic [7:0] v;
      cts_n = 1'b1;
      settle();
      read_stat(v);
      chk("R9 idle before loop", stat_rdata, 8'h00);
      write_ctrl(8'h10);
      @(negedge clk);
      chk("R9 loop no change", stat_rdata, 8'h00);
      write_ctrl(8'h1F);
      chk("R9 outputs idle in loop", {6'd0, rts_n, dtr_n}, 8'h03);
      @(negedge clk);
      chk("R9 all looped levels", stat_rdata, 8'hFB);
      cts_n = 1'b0;
      dcd_n = 1'b0;
      settle();
      chk("R9 external pins ignored", stat_rdata, 8'hFB);
      dcd_n = 1'b1;
      read_stat(v);
      write_ctrl(8'h11);
      @(negedge clk);
      chk("R9 dtr bit to dsr", stat_rdata, 8'h2D);
      read_stat(v);
      write_ctrl(8'h12);
      @(negedge clk);
      chk("R9 rts bit to cts", stat_rdata, 8'h13);
      read_stat(v);
      write_ctrl(8'h14);
      @(negedge clk);
      chk("R9 aux1 to ring", stat_rdata, 8'h41);
      read_stat(v);
      write_ctrl(8'h18);
      @(negedge clk);
      chk("R9 aux2 to carrier", stat_rdata, 8'h8C);
      read_stat(v);
      write_ctrl(8'h00);
      @(negedge clk);
      chk("R9 leave loop pins back", stat_rdata, 8'h19);
      chk("R8 outputs after loop", {6'd0, rts_n, dtr_n}, 8'h03);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_levels();
      t_ri();
      t_sticky_irq();
      t_coincide();
      t_loop();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule